// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source side of a two-layer interrupt scheme. It owns a parameterised bank of interrupt sources, each built as either a level-sensitive source or a message (edge) source, and each with a routing entry: a target server number and an 8-bit priority. A priority of all ones masks the source. The controller turns source activity into delivery requests (server, global number, priority). It sends them one at a time toward the presentation layer. It reacts to the reject, end-of-interrupt and resend messages that come back.

Message sources that are masked when they fire, or whose delivery is rejected, keep a latched record. That record is replayed when the source is unmasked or when a resend walk reaches it. A level source is delivered while its input is high, and only while no delivery for it is outstanding. A resend walk visits the sources one per cycle in index order. Each source kind applies its own replay rule during the walk.

The global number of a source is its local index plus a fixed base (default 4096). Reject and end-of-interrupt messages carry global numbers. The controller maps them back to a local index, and numbers outside its range are ignored.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset no request is offered, every source is masked (priority 0xFF), and all status is clear.
- R2: A request for local source k carries global number k + NUM_BASE (default 4096). Reject and end-of-interrupt numbers outside NUM_BASE..NUM_BASE+NUM_SRC-1 have no effect.
- R3: A one-cycle high on the input of an unmasked message source produces a request carrying that source's configured server and priority. A low input has no effect.
- R4: A message event on a masked source issues nothing and is latched. A later routing write that unmasks the source issues the request and clears the latch.
- R5: A level source issues one request when its input rises while unmasked. Holding the input high issues nothing more. End-of-interrupt clears its in-flight state without issuing.
- R6: A rejected message source is re-sent once by the next resend walk if it is unmasked. If it is masked at that point, its rejected state is dropped, and unmasking later issues nothing.
- R7: A reject clears a level source's in-flight state. The next resend walk re-issues it only if its input is still high.
- R8: End-of-interrupt on a message source has no effect: a following resend walk issues nothing.
- R9: Requests leave one per accepted cycle, lowest source index first. An unaccepted request stays offered while no routing write occurs.
- R10: A queued request whose source is masked before acceptance is withdrawn. A message source latches it as masked-pending, and its unmask re-issues the request. A level source clears its in-flight state, so its unmask re-issues the request if the input is high.
- R11: A resend pulse starts a walk that reaches source k in the k-th cycle after the pulse, so that source's request appears k+1 cycles after the pulse. A new pulse during a walk restarts it at source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Per-source input: a level for level sources, a one-cycle event for message sources |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_idx | input | IDX_W | Local index of the entry being written |
| cfg_server | input | SERVER_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| rej_valid | input | 1 | Reject message strobe |
| rej_num | input | GNUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | GNUM_W | Global number being completed |
| resend_req | input | 1 | Start (or restart) a resend walk |
| req_valid | output | 1 | A delivery request is offered |
| req_ready | input | 1 | The presentation layer accepts the request |
| req_server | output | SERVER_W | Target server of the offered request |
| req_num | output | GNUM_W | Global number of the offered request |
| req_prio | output | 8 | Priority of the offered request |

## Verification
The bench sweeps every source of an eight-source build with four message and four level sources. It computes the expected number, server and priority from the index. The riskiest corners are three. The first is replay of masked or rejected message events: a design that forgot the latch would lose an interrupt, and one that kept the rejected bit after a masked walk would deliver twice. The second is level re-issue: a design that re-sent on every high cycle, or after end-of-interrupt without a walk, would flood the presenter. The third is a source masked while its request waits, which a naive queue would still deliver at priority 0xFF. The walk restart is timed to the cycle, because a walker that ignored the second pulse would deliver the rejected source several cycles early.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
   localparam int unsigned PRIO_W = 8;
   typedef logic [PRIO_W-1:0] prio_t;
   localparam prio_t PRIO_OFF = '1;
   typedef enum logic {SRC_MSG = 1'b0, SRC_LVL = 1'b1} src_kind_e;
endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source: routing entry plus status, variant picked by KIND.
module irq_src_slot
   import irq_src_pkg::*;
#(
   parameter src_kind_e KIND     = SRC_MSG,
   parameter int        SERVER_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_in,
   input  logic                cfg_hit,
   input  logic [SERVER_W-1:0] cfg_server,
   input  prio_t               cfg_prio,
   input  logic                rej_hit,
   input  logic                eoi_hit,
   input  logic                scan_hit,
   input  logic                grant,
   output logic                pend,
   output logic [SERVER_W-1:0] server,
   output prio_t               prio
);
   logic [SERVER_W-1:0] server_q, server_n;
   prio_t prio_q, prio_n;
   logic pend_q, pend_n;
   logic mpend_q, mpend_n;   // message: fired while masked
   logic rej_q, rej_n;       // message: delivery refused
   logic asrt_q, asrt_n;     // level: input state
   logic sent_q, sent_n;     // level: delivery outstanding
   logic do_rule;

   always_comb begin
      server_n = server_q;
      prio_n   = prio_q;
      pend_n   = pend_q & ~grant;
      mpend_n  = mpend_q;
      rej_n    = rej_q;
      asrt_n   = asrt_q;
      sent_n   = sent_q;
      do_rule  = 1'b0;
      if (cfg_hit) begin
         server_n = cfg_server;
         prio_n   = cfg_prio;
      end
      if (KIND == SRC_LVL) begin
         if (ev_in != asrt_q) begin
            asrt_n  = ev_in;
            do_rule = 1'b1;
         end
         if (rej_hit || eoi_hit) sent_n = 1'b0;
         if (cfg_hit || scan_hit) do_rule = 1'b1;
         if (do_rule && (prio_n != PRIO_OFF) && asrt_n && !sent_n) begin
            sent_n = 1'b1;
            pend_n = 1'b1;
         end
         if (pend_n && (prio_n == PRIO_OFF)) begin
            pend_n = 1'b0;
            sent_n = 1'b0;
         end
      end else begin
         if (cfg_hit && mpend_q && (cfg_prio != PRIO_OFF)) begin
            mpend_n = 1'b0;
            pend_n  = 1'b1;
         end
         if (ev_in) begin
            if (prio_n == PRIO_OFF) mpend_n = 1'b1;
            else                    pend_n  = 1'b1;
         end
         if (rej_hit) rej_n = 1'b1;
         if (scan_hit && rej_n) begin
            rej_n = 1'b0;
            if (prio_n != PRIO_OFF) pend_n = 1'b1;
         end
         if (pend_n && (prio_n == PRIO_OFF)) begin
            pend_n  = 1'b0;
            mpend_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         server_q <= '0;
         prio_q   <= PRIO_OFF;
         pend_q   <= 1'b0;
         mpend_q  <= 1'b0;
         rej_q    <= 1'b0;
         asrt_q   <= 1'b0;
         sent_q   <= 1'b0;
      end else begin
         server_q <= server_n;
         prio_q   <= prio_n;
         pend_q   <= pend_n;
         mpend_q  <= mpend_n;
         rej_q    <= rej_n;
         asrt_q   <= asrt_n;
         sent_q   <= sent_n;
      end
   end

   assign pend   = pend_q;
   assign server = server_q;
   assign prio   = prio_q;
endmodule

// File: rtl/irq_low_pick.sv
// Fixed-priority pick: lowest set index wins.
module irq_low_pick #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] want,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] onehot
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (want[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_oh
      assign onehot[i] = any && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/irq_scan_walk.sv
// Sequential resend walk, one source per cycle, restartable.
module irq_scan_walk #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic [NUM_SRC-1:0] hit
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);
   logic             active;
   logic [IDX_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ptr    <= '0;
      end else if (start) begin
         active <= 1'b1;
         ptr    <= '0;
      end else if (active) begin
         if (ptr == LAST) active <= 1'b0;
         else             ptr    <= ptr + IDX_W'(1);
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[i] = active && (ptr == IDX_W'(i));
   end
endmodule

// File: rtl/irq_source_ctl.sv
module irq_source_ctl
   import irq_src_pkg::*;
#(
   parameter int                   NUM_SRC    = 8,
   parameter int                   SERVER_W   = 4,
   parameter int                   GNUM_W     = 16,
   parameter int                   NUM_BASE   = 4096,
   parameter logic [NUM_SRC-1:0]   LEVEL_MASK = '0,
   localparam int                  IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_in,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [SERVER_W-1:0] cfg_server,
   input  logic [7:0]          cfg_prio,
   input  logic                rej_valid,
   input  logic [GNUM_W-1:0]   rej_num,
   input  logic                eoi_valid,
   input  logic [GNUM_W-1:0]   eoi_num,
   input  logic                resend_req,
   output logic                req_valid,
   input  logic                req_ready,
   output logic [SERVER_W-1:0] req_server,
   output logic [GNUM_W-1:0]   req_num,
   output logic [7:0]          req_prio
);
   localparam logic [GNUM_W-1:0] BASE_G = GNUM_W'(NUM_BASE);

   if (NUM_SRC < 1) begin : g_bad_count
      $error("NUM_SRC must be at least 1");
   end
   if (NUM_BASE + NUM_SRC > (1 << GNUM_W)) begin : g_bad_range
      $error("global numbers do not fit in GNUM_W bits");
   end
   if (PRIO_W != 8) begin : g_bad_prio
      $error("priority width must be 8");
   end

   logic [GNUM_W-1:0]   rej_off, eoi_off;
   logic                rej_in, eoi_in;
   logic [NUM_SRC-1:0]  cfg_hit, rej_hit, eoi_hit, scan_hit, grant, pend_v, pick_oh;
   logic [IDX_W-1:0]    pick_idx;
   logic                pick_any;
   logic [SERVER_W-1:0] srv_a [NUM_SRC];
   prio_t               pr_a  [NUM_SRC];

   assign rej_off = rej_num - BASE_G;
   assign eoi_off = eoi_num - BASE_G;
   assign rej_in  = rej_valid && (rej_off < GNUM_W'(NUM_SRC));
   assign eoi_in  = eoi_valid && (eoi_off < GNUM_W'(NUM_SRC));

   irq_scan_walk #(.NUM_SRC(NUM_SRC)) walk_i (
      .clk(clk), .rst_n(rst_n), .start(resend_req), .hit(scan_hit)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam src_kind_e KIND = LEVEL_MASK[i] ? SRC_LVL : SRC_MSG;
      assign cfg_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));
      assign rej_hit[i] = rej_in && (rej_off == GNUM_W'(i));
      assign eoi_hit[i] = eoi_in && (eoi_off == GNUM_W'(i));
      assign grant[i]   = pick_oh[i] && req_ready;

      irq_src_slot #(.KIND(KIND), .SERVER_W(SERVER_W)) slot_i (
         .clk(clk), .rst_n(rst_n), .ev_in(src_in[i]),
         .cfg_hit(cfg_hit[i]), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
         .rej_hit(rej_hit[i]), .eoi_hit(eoi_hit[i]), .scan_hit(scan_hit[i]),
         .grant(grant[i]), .pend(pend_v[i]), .server(srv_a[i]), .prio(pr_a[i])
      );
   end

   irq_low_pick #(.NUM_SRC(NUM_SRC)) pick_i (
      .want(pend_v), .any(pick_any), .idx(pick_idx), .onehot(pick_oh)
   );

   assign req_valid  = pick_any;
   assign req_num    = BASE_G + GNUM_W'(pick_idx);
   assign req_server = srv_a[pick_idx];
   assign req_prio   = pr_a[pick_idx];
endmodule

// File: rtl/irq_source_ctl_chk.sv
module irq_source_ctl_chk #(
   parameter int NUM_SRC  = 8,
   parameter int GNUM_W   = 16,
   parameter int NUM_BASE = 4096
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic               resend_req,
   input logic               req_valid,
   input logic               req_ready,
   input logic [GNUM_W-1:0]  req_num,
   input logic [7:0]         req_prio,
   input logic [NUM_SRC-1:0] scan_hit
);
   localparam logic [GNUM_W-1:0] LO = GNUM_W'(NUM_BASE);
   localparam logic [GNUM_W-1:0] HI = GNUM_W'(NUM_BASE + NUM_SRC);

   always @(posedge clk) begin
      if (!rst_n) assert_reset_idle_R1: assert (!req_valid);
   end

   assert_num_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_num >= LO) && (req_num < HI));

   assert_held_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !cfg_we) |=> req_valid);

   assert_masked_never_offered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_prio != 8'hFF));

   assert_walk_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(scan_hit));

   assert_walk_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req |=> scan_hit[0]);
endmodule

bind irq_source_ctl irq_source_ctl_chk #(
   .NUM_SRC(NUM_SRC), .GNUM_W(GNUM_W), .NUM_BASE(NUM_BASE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .resend_req(resend_req),
   .req_valid(req_valid), .req_ready(req_ready), .req_num(req_num),
   .req_prio(req_prio), .scan_hit(scan_hit)
);

// File: tb/irq_source_ctl_tb_top.sv
module irq_source_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 8;
   localparam int SW   = 4;
   localparam int GW   = 16;
   localparam int BASE = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] src_in = '0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic [SW-1:0] cfg_server = '0;
   logic [7:0] cfg_prio = '0;
   logic rej_valid = 1'b0;
   logic [GW-1:0] rej_num = '0;
   logic eoi_valid = 1'b0;
   logic [GW-1:0] eoi_num = '0;
   logic resend_req = 1'b0;
   logic req_valid, req_ready = 1'b0;
   logic [SW-1:0] req_server;
   logic [GW-1:0] req_num;
   logic [7:0] req_prio;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_source_ctl #(
      .NUM_SRC(N), .SERVER_W(SW), .GNUM_W(GW), .NUM_BASE(BASE), .LEVEL_MASK(8'hF0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rej_valid(rej_valid),
      .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
      .resend_req(resend_req), .req_valid(req_valid), .req_ready(req_ready),
      .req_server(req_server), .req_num(req_num), .req_prio(req_prio)
   );

   function automatic logic [7:0] prio_of(int i);
      return 8'(i * 16 + 2);
   endfunction
   function automatic logic [SW-1:0] srv_of(int i);
      return SW'(i + 1);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wcfg(input int i, input logic [SW-1:0] s, input logic [7:0] p);
      cfg_we = 1'b1; cfg_idx = 3'(i); cfg_server = s; cfg_prio = p;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input int i);
      src_in[i] = 1'b1;
      cyc();
      src_in[i] = 1'b0;
   endtask

   task automatic reject(input int num);
      rej_valid = 1'b1; rej_num = GW'(num);
      cyc();
      rej_valid = 1'b0;
   endtask

   task automatic eoi(input int num);
      eoi_valid = 1'b1; eoi_num = GW'(num);
      cyc();
      eoi_valid = 1'b0;
   endtask

   task automatic resend_all();
      resend_req = 1'b1;
      cyc();
      resend_req = 1'b0;
      repeat (N) cyc();
   endtask

   task automatic expect_req(input int i, input string tag);
      chk(req_valid === 1'b1, {tag, " valid"}, req_valid, 1);
      chk(req_num === GW'(BASE + i), {tag, " number"}, req_num, BASE + i);
      chk(req_server === srv_of(i) && req_prio === prio_of(i), {tag, " server/prio"},
          {req_server, req_prio}, {srv_of(i), prio_of(i)});
      req_ready = 1'b1;
      cyc();
      req_ready = 1'b0;
   endtask

   task automatic expect_none(input string tag);
      chk(req_valid === 1'b0, {tag, " no request"}, req_valid, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc();
      // R1: idle after reset, sources masked
      expect_none("R1 reset");
      pulse(0);
      expect_none("R1 masked after reset");
      // R4: unmask replays the latched event
      wcfg(0, srv_of(0), prio_of(0));
      expect_req(0, "R4 unmask replay");
      expect_none("R4 latch cleared");
      // R2/R3 sweep over message sources
      for (int i = 1; i < 4; i++) wcfg(i, srv_of(i), prio_of(i));
      for (int i = 0; i < 4; i++) begin
         expect_none("R3 low input");
         pulse(i);
         expect_req(i, "R3 R2 message send");
      end
      // R5/R7 sweep over level sources
      for (int i = 4; i < 8; i++) begin
         wcfg(i, srv_of(i), prio_of(i));
         expect_none("R5 unmasked but low");
         src_in[i] = 1'b1;
         cyc();
         expect_req(i, "R5 rising level");
         repeat (3) cyc();
         expect_none("R5 held high");
         eoi(BASE + i);
         expect_none("R5 eoi no reissue");
         resend_all();
         expect_req(i, "R7 walk after eoi");
         reject(BASE + i);
         expect_none("R7 reject alone");
         resend_all();
         expect_req(i, "R7 walk after reject");
         src_in[i] = 1'b0;
         cyc();
         reject(BASE + i);
         resend_all();
         expect_none("R7 deasserted no reissue");
      end
      // R6: message reject and replay
      pulse(1);
      expect_req(1, "R6 first send");
      reject(BASE + 1);
      resend_all();
      expect_req(1, "R6 replay");
      resend_all();
      expect_none("R6 single replay");
      reject(BASE + 1);
      wcfg(1, srv_of(1), 8'hFF);
      resend_all();
      expect_none("R6 masked walk");
      wcfg(1, srv_of(1), prio_of(1));
      expect_none("R6 dropped on masked walk");
      // R8: eoi on message source
      pulse(2);
      expect_req(2, "R8 send");
      eoi(BASE + 2);
      resend_all();
      expect_none("R8 eoi no effect");
      // R2: out-of-range numbers ignored
      pulse(3);
      expect_req(3, "R2 send");
      reject(BASE + N + 3);
      reject(BASE - N + 3);
      resend_all();
      expect_none("R2 out-of-range reject");
      // R9: ordering and hold
      src_in[2:0] = 3'b111;
      cyc();
      src_in[2:0] = 3'b000;
      repeat (3) cyc();
      chk(req_valid === 1'b1 && req_num === GW'(BASE), "R9 held lowest", req_num, BASE);
      expect_req(0, "R9 order first");
      expect_req(1, "R9 order second");
      expect_req(2, "R9 order third");
      expect_none("R9 drained");
      // R10: masking a queued request
      pulse(3);
      wcfg(3, srv_of(3), 8'hFF);
      expect_none("R10 message withdrawn");
      wcfg(3, srv_of(3), prio_of(3));
      expect_req(3, "R10 message replay");
      src_in[4] = 1'b1;
      cyc();
      wcfg(4, srv_of(4), 8'hFF);
      expect_none("R10 level withdrawn");
      wcfg(4, srv_of(4), prio_of(4));
      expect_req(4, "R10 level reissue");
      src_in[4] = 1'b0;
      cyc();
      eoi(BASE + 4);
      // R11: walk timing and restart
      reject(BASE + 3);
      resend_req = 1'b1;
      cyc();
      resend_req = 1'b0;
      cyc();
      resend_req = 1'b1;
      cyc();
      resend_req = 1'b0;
      for (int k = 0; k < 3; k++) begin
         cyc();
         expect_none("R11 restart delays source 3");
      end
      cyc();
      expect_req(3, "R11 walk reaches source 3");
      repeat (N) cyc();
      expect_none("R11 idle");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule